// File: doc/BRIEF.md
# LIN Header Transmitter

This block is the transmit half of a master node's serial port with LIN header support. When transmission is enabled and a break request pulse arrives, it holds the line dominant (low) for a programmable 13 to 16 bit times. It then releases the line recessive (high) for a programmable 1 to 4 bit times as the break delimiter. After that it sends whatever bytes are supplied through a one-entry holding register. Software first writes the sync byte 0x55, then the identifier, then the data bytes. Each byte goes out as an 8N1 character.

Bit timing comes entirely from a single-cycle baud tick made by an external divider. One tick marks the boundary of one bit time, and the line changes only in the cycle after a tick. A transmit-empty flag tells the host when the holding register can take the next byte. The flag sets at the tick that launches the start bit of the byte it held. A level interrupt request follows that flag, gated by an enable input.

A byte may be written right after the break request. It waits in the holding register, and its start bit follows the last delimiter bit with no idle bit between them. A byte written while another is shifting is sent directly after that byte's stop bit.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset the line is high, the transmit-empty flag is 1 and no byte is pending.
- R2: A break request accepted while the header logic is idle makes the line low from the next baud tick for 13 + brk_len_i bit times, where brk_len_i is captured at acceptance (code 0 gives 13, code 3 gives 16).
- R3: The line is high for 1 + dlm_len_i bit times directly after the break, where dlm_len_i is captured at break acceptance.
- R4: A break request seen while tx_en_i is 0 is ignored, so the line stays high.
- R5: Each byte is sent as a low start bit, then 8 data bits with the LSB first, then a high stop bit, each lasting exactly one bit time.
- R6: A write clears the transmit-empty flag in the next cycle. The flag sets again at the baud tick that launches the held byte's start bit.
- R7: tx_irq_o is high exactly when the transmit-empty flag is 1 and irq_en_i is 1.
- R8: A byte written during a pending break, the break or the delimiter is held until the header ends. Its start bit begins at the tick that ends the last delimiter bit.
- R9: A byte written while another byte is shifting starts its start bit at the tick that ends the previous stop bit, with no idle bit.
- R10: The line level changes only in the cycle following a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | One-cycle pulse per bit time |
| tx_en_i | input | 1 | Transmit enable, gates break acceptance |
| brk_req_i | input | 1 | Break request pulse |
| brk_len_i | input | 2 | Break length code, 13 + code bit times |
| dlm_len_i | input | 2 | Delimiter length code, 1 + code bit times |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to send |
| irq_en_i | input | 1 | Transmit interrupt enable |
| tx_empty_o | output | 1 | Holding register empty |
| tx_irq_o | output | 1 | Transmit interrupt request |
| txd_o | output | 1 | Serial line output |

## Verification
The assertions check several properties on every cycle. The line only moves after a tick. A write always clears the empty flag. A launched byte begins with a low level. The break and delimiter states cannot leave without a tick. A disabled request leaves the header logic idle. The interrupt never rises without the empty flag. Only the bench scenarios can show the exact number of low and high bit times for each length code and the LSB-first bit order. They also show that held and back-to-back bytes follow the delimiter or the previous stop bit with no gap.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  typedef enum logic [1:0] {
    HDR_IDLE = 2'd0,
    HDR_PEND = 2'd1,
    HDR_BRK  = 2'd2,
    HDR_DLM  = 2'd3
  } hdr_state_e;
endpackage

// File: rtl/lin_tx_hold.sv
module lin_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_i) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R6
  wr_clears_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_q);
endmodule

// File: rtl/lin_brk_gen.sv
module lin_brk_gen
  import lin_hdr_pkg::*;
#(
  parameter int unsigned LEN_W    = 2,
  parameter int unsigned BRK_BASE = 13,
  parameter int unsigned DLM_BASE = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             tx_en_i,
  input  logic             req_i,
  input  logic [LEN_W-1:0] brk_len_i,
  input  logic [LEN_W-1:0] dlm_len_i,
  input  logic             ser_active_i,
  output logic             idle_o,
  output logic             dlm_end_o,
  output logic             drive_o,
  output logic             level_o
);
  localparam int unsigned MAX_BITS = BRK_BASE + (1 << LEN_W);
  localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);

  hdr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] brk_bits_q, dlm_bits_q;
  logic             brk_last, dlm_last, accept;

  assign accept   = req_i && tx_en_i && (state_q == HDR_IDLE);
  assign brk_last = (cnt_q == brk_bits_q - CNT_W'(1));
  assign dlm_last = (cnt_q == dlm_bits_q - CNT_W'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      HDR_IDLE: if (accept) state_d = HDR_PEND;
      HDR_PEND: if (tick_i && !ser_active_i) begin
        state_d = HDR_BRK;
        cnt_d   = '0;
      end
      HDR_BRK: if (tick_i) begin
        if (brk_last) begin
          state_d = HDR_DLM;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      HDR_DLM: if (tick_i) begin
        if (dlm_last) state_d = HDR_IDLE;
        else          cnt_d   = cnt_q + CNT_W'(1);
      end
      default: state_d = HDR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= HDR_IDLE;
      cnt_q      <= '0;
      brk_bits_q <= CNT_W'(BRK_BASE);
      dlm_bits_q <= CNT_W'(DLM_BASE);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept) begin
        brk_bits_q <= CNT_W'(BRK_BASE) + CNT_W'(brk_len_i);
        dlm_bits_q <= CNT_W'(DLM_BASE) + CNT_W'(dlm_len_i);
      end
    end
  end

  assign idle_o    = (state_q == HDR_IDLE);
  assign dlm_end_o = (state_q == HDR_DLM) && tick_i && dlm_last;
  assign drive_o   = (state_q == HDR_BRK) || (state_q == HDR_DLM);
  assign level_o   = (state_q == HDR_DLM);

  // R4
  brk_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !tx_en_i && state_q == HDR_IDLE) |=> state_q == HDR_IDLE);
  // R2
  brk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HDR_BRK && !tick_i) |=> state_q == HDR_BRK);
  // R3
  dlm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HDR_DLM && !tick_i) |=> state_q == HDR_DLM);
endmodule

// File: rtl/lin_byte_ser.sv
module lin_byte_ser #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              active_o,
  output logic              last_o,
  output logic              txd_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic               active_q;

  assign last_o = active_q && (idx_q == IDX_W'(FRAME_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q  <= '1;
      idx_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      frame_q  <= {1'b1, data_i, 1'b0};
      idx_q    <= '0;
      active_q <= 1'b1;
    end else if (tick_i && active_q) begin
      if (last_o) begin
        active_q <= 1'b0;
        frame_q  <= '1;
      end else begin
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        idx_q   <= idx_q + IDX_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign txd_o    = active_q ? frame_q[0] : 1'b1;

  // R5
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_q && !txd_o));
endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LEN_W    = 2,
  parameter int unsigned BRK_BASE = 13,
  parameter int unsigned DLM_BASE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              tx_en_i,
  input  logic              brk_req_i,
  input  logic [LEN_W-1:0]  brk_len_i,
  input  logic [LEN_W-1:0]  dlm_len_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              irq_en_i,
  output logic              tx_empty_o,
  output logic              tx_irq_o,
  output logic              txd_o
);
  logic              buf_full, ser_active, ser_last, ser_txd, ser_start;
  logic              hdr_idle, hdr_dlm_end, hdr_drive, hdr_level;
  logic [DATA_W-1:0] buf_data;

  lin_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni,
    .wr_i, .wr_data_i,
    .take_i (ser_start),
    .full_o (buf_full),
    .data_o (buf_data)
  );

  lin_brk_gen #(.LEN_W(LEN_W), .BRK_BASE(BRK_BASE), .DLM_BASE(DLM_BASE)) u_brk (
    .clk_i, .rst_ni,
    .tick_i       (baud_tick_i),
    .tx_en_i,
    .req_i        (brk_req_i),
    .brk_len_i, .dlm_len_i,
    .ser_active_i (ser_active),
    .idle_o       (hdr_idle),
    .dlm_end_o    (hdr_dlm_end),
    .drive_o      (hdr_drive),
    .level_o      (hdr_level)
  );

  // launch at a tick: line free (idle or finishing stop bit), header idle or ending
  assign ser_start = baud_tick_i && buf_full && (!ser_active || ser_last)
                     && (hdr_idle || hdr_dlm_end);

  lin_byte_ser #(.DATA_W(DATA_W)) u_ser (
    .clk_i, .rst_ni,
    .tick_i   (baud_tick_i),
    .start_i  (ser_start),
    .data_i   (buf_data),
    .active_o (ser_active),
    .last_o   (ser_last),
    .txd_o    (ser_txd)
  );

  assign txd_o      = hdr_drive ? hdr_level : ser_txd;
  assign tx_empty_o = !buf_full;
  assign tx_irq_o   = irq_en_i && !buf_full;

  // R10
  line_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !baud_tick_i |=> $stable(txd_o));
  // R7
  irq_needs_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> tx_empty_o);
  // R6
  empty_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_start && !wr_i) |=> tx_empty_o);
endmodule

// File: tb/lin_hdr_tx_test.sv
module lin_hdr_tx_test;
  localparam int unsigned DIV = 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0, baud_tick_i = 1'b0;
  logic       tx_en_i = 1'b0, brk_req_i = 1'b0, wr_i = 1'b0, irq_en_i = 1'b0;
  logic [1:0] brk_len_i = '0, dlm_len_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       tx_empty_o, tx_irq_o, txd_o;

  int n_chk = 0, n_bad = 0, tick_cnt = 0;

  lin_hdr_tx uut (.*);

  always #5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      tick_cnt    = 0;
      baud_tick_i = 1'b0;
    end else begin
      baud_tick_i = (tick_cnt == DIV - 1);
      tick_cnt    = (tick_cnt == DIV - 1) ? 0 : tick_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // returns line level for the bit started at the next tick
  task automatic next_bit(output logic b);
    do @(posedge clk_i); while (!baud_tick_i);
    #2 b = txd_o;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic check_frame(input string req, input logic [7:0] d, input logic first_sampled,
                             input logic start_val);
    logic b;
    chk({req, " start"}, start_val, 0);
    for (int i = 0; i < 8; i++) begin
      next_bit(b);
      chk({req, " data"}, b, d[i]);
    end
    next_bit(b);
    chk({req, " stop"}, b, 1);
    if (first_sampled) chk({req, " tx_empty at end"}, tx_empty_o, 1);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 txd", txd_o, 1);
    chk("R1 empty", tx_empty_o, 1);
    chk("R1 irq off", tx_irq_o, 0);
  endtask

  task automatic t_header(input logic [1:0] bl, input logic [1:0] dl, input logic [7:0] d);
    logic b;
    int lows = 0, highs = 0;
    next_bit(b);
    @(negedge clk_i);
    tx_en_i = 1'b1; brk_req_i = 1'b1; brk_len_i = bl; dlm_len_i = dl;
    @(negedge clk_i);
    brk_req_i = 1'b0; brk_len_i = ~bl; dlm_len_i = ~dl;
    wr_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
    chk("R6 empty clears", tx_empty_o, 0);
    chk("R7 irq low when full", tx_irq_o, 0);
    for (int i = 0; i < 13 + int'(bl); i++) begin
      next_bit(b);
      if (b == 0) lows++;
    end
    chk("R2 break bits low", lows, 13 + int'(bl));
    for (int i = 0; i < 1 + int'(dl); i++) begin
      next_bit(b);
      if (b == 1) highs++;
    end
    chk("R3 delimiter bits high", highs, 1 + int'(dl));
    chk("R8 byte still held", tx_empty_o, 0);
    next_bit(b);
    chk("R6 empty at start bit", tx_empty_o, 1);
    chk("R7 irq with empty", tx_irq_o, int'(irq_en_i));
    check_frame("R8 R5", d, 1'b0, b);
  endtask

  task automatic t_gated();
    logic b;
    int highs = 0;
    next_bit(b);
    @(negedge clk_i);
    tx_en_i = 1'b0; brk_req_i = 1'b1;
    @(negedge clk_i);
    brk_req_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      next_bit(b);
      if (b == 1) highs++;
    end
    chk("R4 line stays high", highs, 20);
    tx_en_i = 1'b1;
  endtask

  task automatic t_b2b(input logic [7:0] a, input logic [7:0] c);
    logic b;
    next_bit(b);
    write_byte(a);
    next_bit(b);
    chk("R9 first start", b, 0);
    write_byte(c);
    chk("R9 second held", tx_empty_o, 0);
    for (int i = 0; i < 8; i++) begin
      next_bit(b);
      chk("R5 R9 first data", b, a[i]);
    end
    next_bit(b);
    chk("R9 first stop", b, 1);
    next_bit(b);
    chk("R9 no idle gap", tx_empty_o, 1);
    check_frame("R9 R5 second", c, 1'b1, b);
    next_bit(b);
    chk("R10 idle after frame", b, 1);
  endtask

  task automatic t_irq();
    @(negedge clk_i);
    irq_en_i = 1'b0;
    #1 chk("R7 irq disabled", tx_irq_o, 0);
    @(negedge clk_i);
    irq_en_i = 1'b1;
    #1 chk("R7 irq enabled", tx_irq_o, 1);
  endtask

  initial begin
    #200_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1 t_reset();
    #30 @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_irq();
    t_header(2'd0, 2'd0, 8'h55);
    irq_en_i = 1'b0;
    t_header(2'd3, 2'd3, 8'h3c);
    irq_en_i = 1'b1;
    t_header(2'd2, 2'd1, 8'hA7);
    t_gated();
    t_b2b(8'hC1, 8'h5E);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule